// File: doc/BRIEF.md
# Neighbour Chain Exchange Unit

This unit sits at the tail of a parallel-tempering sampler pipeline, after the per-chain accept stage and before write-back to the sample and log-density stores. Updated chains arrive one per valid cycle in ascending index order. Each arrival carries its sample word, its log-density and its temperature factor. The unit groups adjacent chains into exchange pairs and decides whether to trade their states. It then writes both chains back together.

The lower chain of a pair waits in a small show-ahead FIFO until its upper partner arrives. No memory round trip is needed. On the partner's arrival a four-stage pipeline runs. It forms the four temperature-times-log-density products in parallel, sums the cross and own terms, takes their difference, and compares that log ratio with a log-uniform random input. On acceptance the two chains trade samples and log-densities, and each index slot keeps its own temperature. The pairing offset alternates between iterations. A chain at either end that has no partner passes through untouched. All arithmetic is signed fixed point: log-densities are integers, and temperatures carry FRAC fraction bits.

Top module: `xchg_neighbour_unit`

## Requirements
- R1: After reset, and in the cycle after any cycle with rst high, wb_valid_a, wb_valid_b, wb_swapped, iter_done and odd_pairing are all 0.
- R2: With odd_pairing = 0 the pairs are (0,1),(2,3),…; with odd_pairing = 1 they are (1,2),(3,4),…. odd_pairing inverts on the cycle after an input with in_idx = NCHAIN-1 is taken, and holds otherwise.
- R3: A chain without a partner in the current pairing is written back on slot a with its own sample and log-density, with wb_valid_b = 0 and wb_swapped = 0.
- R4: For a pair with lower chain j and upper chain k = j+1, the exchange is accepted iff T_j·L_k + T_k·L_j − T_j·L_j − T_k·L_k ≥ rnd·2^FRAC. Here rnd is in_rnd sampled with chain k, and equality accepts.
- R5: On acceptance, slot a (index j) carries chain k's sample and log-density and slot b (index k) carries chain j's, with wb_swapped = 1. On rejection both are unchanged and wb_swapped = 0.
- R6: A pair is written back on both slots in one cycle, four clock edges after the edge that takes its upper chain. A lone chain is written back four edges after its own input edge.
- R7: iter_done is high for exactly the write-back cycles that include index NCHAIN-1, once per iteration.
- R8: Write-back follows ascending index order, and wb_idx_b = wb_idx_a + 1 whenever wb_valid_b is high.
- R9: The lower chain of a pair produces no write-back on its own; it is held until its partner arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An updated chain is presented |
| in_idx | input | IDX_W | Index of the presented chain |
| in_sample | input | SMP_W | Updated sample word |
| in_logp | input | LP_W | Updated log-density, signed |
| in_temp | input | TMP_W | Temperature factor, unsigned, FRAC fraction bits |
| in_rnd | input | LP_W | Log of a uniform random number, signed |
| wb_valid_a | output | 1 | Slot a write-back valid |
| wb_idx_a | output | IDX_W | Slot a chain index |
| wb_sample_a | output | SMP_W | Slot a sample |
| wb_logp_a | output | LP_W | Slot a log-density |
| wb_valid_b | output | 1 | Slot b write-back valid (pairs only) |
| wb_idx_b | output | IDX_W | Slot b chain index |
| wb_sample_b | output | SMP_W | Slot b sample |
| wb_logp_b | output | LP_W | Slot b log-density |
| wb_swapped | output | 1 | The pair on the slots was exchanged |
| iter_done | output | 1 | Last chain of the iteration written back |
| odd_pairing | output | 1 | Current pairing offset |

## Verification
The per-cycle checks cover the structural rules. These are the quiet state after reset, the phase flip and hold around the last index, slot b appearing only with slot a and the next index, swaps only on full pairs, the four-edge latency, and iter_done only alongside the last chain. The bench scenarios are needed for the decision and the data routing. They show that the ratio comparison accepts and rejects correctly, including the equality boundary. They also show that swapped payloads land in the right slots, that end chains in both phases pass unchanged, and that back-to-back and gapped streams give the same results.

// File: rtl/xchg_pkg.sv
`timescale 1ns/1ps
package xchg_pkg;

  typedef enum logic [1:0] {
    ROLE_SOLO  = 2'd0,
    ROLE_LOWER = 2'd1,
    ROLE_UPPER = 2'd2
  } role_e;

  // Role of a chain index under the current pairing offset.
  function automatic role_e pair_role(input int unsigned idx,
                                      input logic        odd_ph,
                                      input int unsigned nchain);
    logic opens;
    opens = (idx[0] == odd_ph);
    if (opens && ((idx + 1) < nchain)) return ROLE_LOWER;
    if (!opens && (idx >= 1)) return ROLE_UPPER;
    return ROLE_SOLO;
  endfunction

endpackage

// File: rtl/xchg_fifo.sv
`timescale 1ns/1ps
module xchg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
endmodule

// File: rtl/xchg_ratio.sv
`timescale 1ns/1ps
module xchg_ratio #(
  parameter int LW   = 16,
  parameter int TW   = 10,
  parameter int FRAC = 8,
  parameter int PAYW = 8,
  localparam int PW  = LW + TW + 1,
  localparam int SW2 = PW + 1,
  localparam int DW  = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go,
  input  logic [TW-1:0]        t_lo,
  input  logic [TW-1:0]        t_hi,
  input  logic signed [LW-1:0] l_lo,
  input  logic signed [LW-1:0] l_hi,
  input  logic signed [LW-1:0] rnd,
  input  logic [PAYW-1:0]      pay_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] dif_o,
  output logic signed [DW-1:0] thr_o,
  output logic [PAYW-1:0]      pay_o
);
  function automatic logic signed [PW-1:0] tl(input logic [TW-1:0] t,
                                              input logic signed [LW-1:0] l);
    logic signed [PW-1:0] te, le;
    te = $signed({{(PW-TW){1'b0}}, t});
    le = $signed({{(PW-LW){l[LW-1]}}, l});
    return te * le;
  endfunction

  logic signed [DW-1:0] thr0;
  always_comb begin
    thr0 = $signed({{(DW-LW){rnd[LW-1]}}, rnd});
    thr0 = thr0 <<< FRAC;
  end

  // stage 1: four products
  logic                 v1;
  logic signed [PW-1:0] xa1, xb1, oa1, ob1;
  logic signed [DW-1:0] thr1;
  logic [PAYW-1:0]      pay1;
  // stage 2: cross and own sums
  logic                  v2;
  logic signed [SW2-1:0] num2, den2;
  logic signed [DW-1:0]  thr2;
  logic [PAYW-1:0]       pay2;
  // stage 3: log ratio
  logic                 v3;
  logic signed [DW-1:0] dif3, thr3;
  logic [PAYW-1:0]      pay3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= go;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    xa1  <= tl(t_lo, l_hi);
    xb1  <= tl(t_hi, l_lo);
    oa1  <= tl(t_lo, l_lo);
    ob1  <= tl(t_hi, l_hi);
    thr1 <= thr0;
    pay1 <= pay_i;

    num2 <= $signed({xa1[PW-1], xa1}) + $signed({xb1[PW-1], xb1});
    den2 <= $signed({oa1[PW-1], oa1}) + $signed({ob1[PW-1], ob1});
    thr2 <= thr1;
    pay2 <= pay1;

    dif3 <= $signed({num2[SW2-1], num2}) - $signed({den2[SW2-1], den2});
    thr3 <= thr2;
    pay3 <= pay2;
  end

  assign vld_o = v3;
  assign dif_o = dif3;
  assign thr_o = thr3;
  assign pay_o = pay3;
endmodule

// File: rtl/xchg_neighbour_unit.sv
`timescale 1ns/1ps
module xchg_neighbour_unit #(
  parameter int NCHAIN     = 5,
  parameter int SMP_W      = 16,
  parameter int LP_W       = 16,
  parameter int TMP_W      = 10,
  parameter int FRAC       = 8,
  parameter int FIFO_DEPTH = 2,
  localparam int IDX_W     = (NCHAIN > 1) ? $clog2(NCHAIN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IDX_W-1:0]        in_idx,
  input  logic [SMP_W-1:0]        in_sample,
  input  logic signed [LP_W-1:0]  in_logp,
  input  logic [TMP_W-1:0]        in_temp,
  input  logic signed [LP_W-1:0]  in_rnd,
  output logic                    wb_valid_a,
  output logic [IDX_W-1:0]        wb_idx_a,
  output logic [SMP_W-1:0]        wb_sample_a,
  output logic signed [LP_W-1:0]  wb_logp_a,
  output logic                    wb_valid_b,
  output logic [IDX_W-1:0]        wb_idx_b,
  output logic [SMP_W-1:0]        wb_sample_b,
  output logic signed [LP_W-1:0]  wb_logp_b,
  output logic                    wb_swapped,
  output logic                    iter_done,
  output logic                    odd_pairing
);
  import xchg_pkg::*;

  localparam int PW     = LP_W + TMP_W + 1;
  localparam int DW     = PW + 2;
  localparam int HOLD_W = SMP_W + LP_W + TMP_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHAIN - 1);

  typedef struct packed {
    logic             solo;
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] s_lo;
    logic [LP_W-1:0]  l_lo;
    logic [SMP_W-1:0] s_hi;
    logic [LP_W-1:0]  l_hi;
  } pay_t;
  localparam int PAYW = $bits(pay_t);

  // pairing offset
  logic phase;
  always_ff @(posedge clk) begin
    if (rst)                             phase <= 1'b0;
    else if (in_valid && in_idx == LAST) phase <= ~phase;
  end
  assign odd_pairing = phase;

  role_e role;
  assign role = pair_role(32'(in_idx), phase, 32'(NCHAIN));

  // hold buffer for the lower partner
  logic              hold_push, hold_pop, hold_empty;
  logic [HOLD_W-1:0] hold_din, hold_dout;
  logic [SMP_W-1:0]  h_smp;
  logic [LP_W-1:0]   h_lp;
  logic [TMP_W-1:0]  h_tmp;

  assign hold_push = in_valid && (role == ROLE_LOWER);
  assign hold_pop  = in_valid && (role == ROLE_UPPER) && !hold_empty;
  assign hold_din  = {in_sample, in_logp, in_temp};
  assign {h_smp, h_lp, h_tmp} = hold_dout;

  xchg_fifo #(.W(HOLD_W), .DEPTH(FIFO_DEPTH)) hold_i (
    .clk  (clk),
    .rst  (rst),
    .push (hold_push),
    .din  (hold_din),
    .pop  (hold_pop),
    .dout (hold_dout),
    .empty(hold_empty)
  );

  // launch into the ratio pipeline
  logic              launch, solo_in;
  pay_t              pay_in;
  logic [TMP_W-1:0]  t_lo, t_hi;

  assign launch  = in_valid && (role != ROLE_LOWER);
  assign solo_in = (role == ROLE_SOLO) || hold_empty;

  always_comb begin
    pay_in.solo = solo_in;
    pay_in.idx  = solo_in ? in_idx : in_idx - IDX_W'(1);
    pay_in.s_lo = solo_in ? in_sample : h_smp;
    pay_in.l_lo = solo_in ? in_logp   : h_lp;
    pay_in.s_hi = solo_in ? '0 : in_sample;
    pay_in.l_hi = solo_in ? '0 : in_logp;
    t_lo        = solo_in ? '0 : h_tmp;
    t_hi        = solo_in ? '0 : in_temp;
  end

  logic                 r_v;
  logic signed [DW-1:0] r_dif, r_thr;
  pay_t                 r_pay;

  xchg_ratio #(.LW(LP_W), .TW(TMP_W), .FRAC(FRAC), .PAYW(PAYW)) ratio_i (
    .clk  (clk),
    .rst  (rst),
    .go   (launch),
    .t_lo (t_lo),
    .t_hi (t_hi),
    .l_lo ($signed(pay_in.l_lo)),
    .l_hi ($signed(pay_in.l_hi)),
    .rnd  (in_rnd),
    .pay_i(pay_in),
    .vld_o(r_v),
    .dif_o(r_dif),
    .thr_o(r_thr),
    .pay_o(r_pay)
  );

  // compare and write-back register
  logic             accept, swap;
  logic [IDX_W-1:0] top_idx;
  assign accept  = (r_dif >= r_thr);
  assign swap    = !r_pay.solo && accept;
  assign top_idx = r_pay.solo ? r_pay.idx : r_pay.idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_a  <= 1'b0;
      wb_valid_b  <= 1'b0;
      wb_swapped  <= 1'b0;
      iter_done   <= 1'b0;
      wb_idx_a    <= '0;
      wb_idx_b    <= '0;
      wb_sample_a <= '0;
      wb_sample_b <= '0;
      wb_logp_a   <= '0;
      wb_logp_b   <= '0;
    end else begin
      wb_valid_a <= r_v;
      wb_valid_b <= r_v && !r_pay.solo;
      wb_swapped <= r_v && swap;
      iter_done  <= r_v && (top_idx == LAST);
      if (r_v) begin
        wb_idx_a    <= r_pay.idx;
        wb_idx_b    <= r_pay.idx + IDX_W'(1);
        wb_sample_a <= swap ? r_pay.s_hi : r_pay.s_lo;
        wb_logp_a   <= swap ? r_pay.l_hi : r_pay.l_lo;
        wb_sample_b <= swap ? r_pay.s_lo : r_pay.s_hi;
        wb_logp_b   <= swap ? r_pay.l_lo : r_pay.l_hi;
      end
    end
  end
endmodule

// File: rtl/xchg_neighbour_unit_chk.sv
`timescale 1ns/1ps
module xchg_neighbour_unit_chk #(
  parameter int NCHAIN = 5,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IDX_W-1:0] in_idx,
  input logic             odd_pairing,
  input logic             wb_valid_a,
  input logic [IDX_W-1:0] wb_idx_a,
  input logic             wb_valid_b,
  input logic [IDX_W-1:0] wb_idx_b,
  input logic             wb_swapped,
  input logic             iter_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHAIN - 1);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!wb_valid_a && !wb_valid_b && !wb_swapped && !iter_done && !odd_pairing)); // R1

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_idx == LAST) |=> (odd_pairing != $past(odd_pairing))); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_idx == LAST) |=> $stable(odd_pairing)); // R2

  AST_SWAP_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    wb_swapped |-> wb_valid_b); // R5

  AST_WB_LATENCY: assert property (@(posedge clk) disable iff (rst)
    wb_valid_a |-> $past(in_valid, 4)); // R6

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    iter_done |-> ((wb_valid_a && wb_idx_a == LAST) || (wb_valid_b && wb_idx_b == LAST))); // R7

  AST_UPPER_FOLLOWS_LOWER: assert property (@(posedge clk) disable iff (rst)
    wb_valid_b |-> (wb_valid_a && wb_idx_b == wb_idx_a + IDX_W'(1))); // R8
endmodule

bind xchg_neighbour_unit xchg_neighbour_unit_chk #(.NCHAIN(NCHAIN), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_idx     (in_idx),
  .odd_pairing(odd_pairing),
  .wb_valid_a (wb_valid_a),
  .wb_idx_a   (wb_idx_a),
  .wb_valid_b (wb_valid_b),
  .wb_idx_b   (wb_idx_b),
  .wb_swapped (wb_swapped),
  .iter_done  (iter_done)
);

// File: tb/xchg_neighbour_unit_tb_top.sv
`timescale 1ns/1ps
module xchg_neighbour_unit_tb_top;
  localparam int M    = 5;
  localparam int IW   = 3;
  localparam int NVEC = 20;

  // entry: {sample[16], logp[16], temp[10], rnd[16]}; chain index = entry % M,
  // iteration = entry / M (phases even, odd, even, odd)
  localparam logic [57:0] VEC [NVEC] = '{
    {16'h1000, -16'sd40,  10'd256, 16'sd0},
    {16'h1001, -16'sd20,  10'd224, -16'sd5},
    {16'h1002, -16'sd10,  10'd192, 16'sd0},
    {16'h1003, -16'sd60,  10'd160, -16'sd3},
    {16'h1004, -16'sd70,  10'd128, -16'sd100},
    {16'h2000, -16'sd5,   10'd256, -16'sd100},
    {16'h2001, -16'sd30,  10'd224, 16'sd0},
    {16'h2002, -16'sd30,  10'd192, 16'sd0},
    {16'h2003, -16'sd8,   10'd160, 16'sd0},
    {16'h2004, -16'sd90,  10'd128, -16'sd20},
    {16'h3000, -16'sd100, 10'd256, 16'sd0},
    {16'h3001, -16'sd50,  10'd128, 16'sd25},
    {16'h3002, -16'sd50,  10'd256, 16'sd0},
    {16'h3003, -16'sd100, 10'd128, -16'sd10},
    {16'h3004, -16'sd1,   10'd128, 16'sd0},
    {16'h4000, -16'sd1,   10'd256, 16'sd0},
    {16'h4001, -16'sd100, 10'd256, 16'sd0},
    {16'h4002, -16'sd50,  10'd128, 16'sd26},
    {16'h4003, -16'sd10,  10'd200, 16'sd0},
    {16'h4004, -16'sd10,  10'd100, 16'sd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IW-1:0] in_idx = '0;
  logic [15:0] in_sample = '0;
  logic signed [15:0] in_logp = '0;
  logic [9:0] in_temp = '0;
  logic signed [15:0] in_rnd = '0;
  logic wb_valid_a, wb_valid_b, wb_swapped, iter_done, odd_pairing;
  logic [IW-1:0] wb_idx_a, wb_idx_b;
  logic [15:0] wb_sample_a, wb_sample_b;
  logic signed [15:0] wb_logp_a, wb_logp_b;

  always #5 clk = ~clk;

  xchg_neighbour_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
    .in_sample(in_sample), .in_logp(in_logp), .in_temp(in_temp), .in_rnd(in_rnd),
    .wb_valid_a(wb_valid_a), .wb_idx_a(wb_idx_a), .wb_sample_a(wb_sample_a),
    .wb_logp_a(wb_logp_a), .wb_valid_b(wb_valid_b), .wb_idx_b(wb_idx_b),
    .wb_sample_b(wb_sample_b), .wb_logp_b(wb_logp_b), .wb_swapped(wb_swapped),
    .iter_done(iter_done), .odd_pairing(odd_pairing)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit fin = 1'b0;
  int drv_cyc [NVEC];

  int rec_n = 0;
  int rec_idx [64];
  int rec_smp [64];
  int rec_lp  [64];
  int rec_sw  [64];
  int rec_slot[64];
  int rec_solo[64];
  int rec_cyc [64];
  int done_cnt = 0;
  int done_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (wb_valid_a && rec_n < 64) begin
        rec_idx[rec_n] = int'(wb_idx_a);  rec_smp[rec_n] = int'(wb_sample_a);
        rec_lp[rec_n]  = int'(wb_logp_a); rec_sw[rec_n]  = int'(wb_swapped);
        rec_slot[rec_n] = 0; rec_solo[rec_n] = int'(!wb_valid_b); rec_cyc[rec_n] = cyc;
        rec_n++;
      end
      if (wb_valid_b && rec_n < 64) begin
        rec_idx[rec_n] = int'(wb_idx_b);  rec_smp[rec_n] = int'(wb_sample_b);
        rec_lp[rec_n]  = int'(wb_logp_b); rec_sw[rec_n]  = int'(wb_swapped);
        rec_slot[rec_n] = 1; rec_solo[rec_n] = 0; rec_cyc[rec_n] = cyc;
        rec_n++;
      end
      if (iter_done) begin
        done_cnt++;
        if (!((wb_valid_a && wb_idx_a == IW'(M-1)) || (wb_valid_b && wb_idx_b == IW'(M-1))))
          done_bad++;
      end
    end
  end

  function automatic int v_smp(int e); return int'(VEC[e][57:42]); endfunction
  function automatic int v_lp(int e);  return int'($signed(VEC[e][41:26])); endfunction
  function automatic int v_tmp(int e); return int'(VEC[e][25:16]); endfunction
  function automatic int v_rnd(int e); return int'($signed(VEC[e][15:0])); endfunction

  // R4 model in factored form: (T_lo - T_hi)(L_hi - L_lo) >= rnd * 2^8
  function automatic bit exp_acc(int lo);
    return ((v_tmp(lo) - v_tmp(lo+1)) * (v_lp(lo+1) - v_lp(lo))) >= (v_rnd(lo+1) * 256);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int e, input int gap);
    in_valid  = 1'b1;
    in_idx    = IW'(e % M);
    in_sample = VEC[e][57:42];
    in_logp   = $signed(VEC[e][41:26]);
    in_temp   = VEC[e][25:16];
    in_rnd    = $signed(VEC[e][15:0]);
    drv_cyc[e] = cyc;
    @(negedge clk);
    if (gap > 0) begin
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rec_n, NVEC);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wb_valid_a && !wb_valid_b, "R1", "valids in reset", int'(wb_valid_a | wb_valid_b), 0);
    chk(!iter_done && !wb_swapped, "R1", "flags in reset", int'(iter_done | wb_swapped), 0);
    chk(!odd_pairing, "R1", "pairing in reset", int'(odd_pairing), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: three back-to-back iterations, then one with gaps
    for (int e = 0; e < NVEC; e++) begin
      send(e, (e >= 15) ? 2 : 0);
      if (e == 4)  chk(odd_pairing == 1'b1, "R2", "phase after iter 0", int'(odd_pairing), 1);
      if (e == 9)  chk(odd_pairing == 1'b0, "R2", "phase after iter 1", int'(odd_pairing), 0);
    end
    in_valid = 1'b0;
    repeat (10) @(negedge clk);

    chk(rec_n == NVEC, "R8", "record count", rec_n, NVEC);
    for (int e = 0; e < NVEC && e < rec_n; e++) begin
      int j, odd, up, dn, acc, esmp, elp, launch_e;
      j   = e % M;
      odd = (e / M) % 2;
      up  = ((j % 2) == odd) && (j + 1 < M);
      dn  = (j >= 1) && (((j - 1) % 2) == odd);
      acc = up ? int'(exp_acc(e)) : (dn ? int'(exp_acc(e - 1)) : 0);
      esmp = v_smp(e);
      elp  = v_lp(e);
      if (acc != 0 && up != 0) begin esmp = v_smp(e + 1); elp = v_lp(e + 1); end
      if (acc != 0 && dn != 0) begin esmp = v_smp(e - 1); elp = v_lp(e - 1); end
      launch_e = (up != 0) ? e + 1 : e;
      chk(rec_idx[e] == j, "R8", "write-back order", rec_idx[e], j);
      chk(rec_slot[e] == dn, "R2", "pair slot", rec_slot[e], dn);
      chk(rec_solo[e] == int'(up == 0 && dn == 0), "R3", "lone chain", rec_solo[e],
          int'(up == 0 && dn == 0));
      chk(rec_sw[e] == acc, "R4", "exchange decision", rec_sw[e], acc);
      chk(rec_smp[e] == esmp, "R5", "sample routing", rec_smp[e], esmp);
      chk(rec_lp[e] == elp, "R5", "logp routing", rec_lp[e], elp);
      // R6 latency; for a lower chain this also shows it was held (R9)
      chk(rec_cyc[e] == drv_cyc[launch_e] + 4, (up != 0) ? "R9" : "R6", "write-back cycle",
          rec_cyc[e], drv_cyc[launch_e] + 4);
    end
    chk(done_cnt == 4, "R7", "iteration pulses", done_cnt, 4);
    chk(done_bad == 0, "R7", "pulse without last chain", done_bad, 0);

    // directed: lone last chain in even phase, then mid-run reset
    in_valid = 1'b1; in_idx = IW'(M-1); in_sample = 16'h5555; in_logp = -16'sd7;
    in_temp = 10'd50; in_rnd = 16'sd0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(odd_pairing == 1'b1, "R2", "phase after lone last", int'(odd_pairing), 1);
    repeat (6) @(negedge clk);
    chk(rec_n == NVEC + 1, "R3", "lone record count", rec_n, NVEC + 1);
    chk(rec_smp[NVEC] == 16'h5555 && rec_solo[NVEC] == 1 && rec_sw[NVEC] == 0, "R3",
        "lone chain unchanged", rec_smp[NVEC], 16'h5555);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!odd_pairing, "R1", "pairing after reset", int'(odd_pairing), 0);
    chk(!wb_valid_a && !iter_done, "R1", "outputs after reset", int'(wb_valid_a | iter_done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule